// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that finishes one instruction per clock. Every instruction is a fixed 32-bit word. In each cycle the core reads the word at the program counter from its instruction store, decodes it, and reads two operands from a 32-entry register file. It then produces an arithmetic, logic or address result and writes it back, stores to the data memory, or takes a conditional branch. The counter moves to the next word or to the branch target at the same clock edge.

It supports register-to-register arithmetic and logic, immediate arithmetic and logic with a different immediate extension for each class, word load and store, and branch-on-equal. Both memories are filled through a write-only load port, normally while reset is held. While the core runs, a debug tap shows the program counter and any register picked by a debug address.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0 and all 32 registers become 0. No store takes place during reset.
- R2: After any instruction other than a taken branch, the program counter rises by 4 at the next edge. The instruction word is fetched from instruction memory index pc[9:2].
- R3: Register instructions use opcode 0 with fields rs[25:21], rt[20:16] and rd[15:11]. The funct field in bits [5:0] selects the operation: 0x20 is add, 0x23 is subtract, 0x24 is AND, 0x25 is OR, 0x26 is XOR and 0x27 is NOR. Each writes its result to rd. Add and subtract wrap modulo 2^32 and raise no overflow flag.
- R4: funct 0x2A with opcode 0 writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R5: Opcode 0x08 writes to rt the sum of rs and the 16-bit immediate in bits [15:0], after imm[15] has been copied into the upper 16 bits.
- R6: Opcodes 0x0C and 0x0D write to rt the value rs AND, or rs OR, the immediate with 16 zero bits placed above it.
- R7: Opcode 0x0F writes the immediate followed by 16 zero bits to rt.
- R8: Opcode 0x2B stores rt to data memory, and opcode 0x23 loads a data word into rt. In both cases the address is rs plus the sign-extended immediate, and the word index is address[9:2]. A load reads a word placed through the load port as well as a word written by a store.
- R9: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. If they differ, the next PC is PC+4. Backward offsets are allowed.
- R10: Register 0 always reads as zero. A write that targets it is dropped.
- R11: An unknown opcode, or opcode 0 with an unlisted funct, changes no register and no memory, and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write one word into a memory at this edge |
| loadToData | input | 1 | 1 selects data memory, 0 selects instruction memory |
| loadAddr | input | 8 | Word index for the load port |
| loadData | input | 32 | Word written by the load port |
| dbgRegAddr | input | 5 | Register number shown on dbgRegData |
| dbgPc | output | 32 | Current program counter |
| dbgRegData | output | 32 | Contents of the register picked by dbgRegAddr |

## Verification
A decode error leaves the destination register wrong, or leaves a register changed that should be untouched. The error shows on the debug read port as soon as that register is selected, and it also spreads to every later instruction that reads it. A wrong program counter or branch target shows on `dbgPc` in the very next cycle. Because of that, the loop count and the final halt address both expose control faults. A wrong memory index or a lost store shows up as a wrong value loaded into a register a few instructions later.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LUI  = 6'h0F;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_PASS
  } aluOp_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } immKind_e;

  typedef struct packed {
    logic     regWrite;
    logic     destRd;
    logic     useImm;
    immKind_e immKind;
    aluOp_e   aluOp;
    logic     memToReg;
    logic     memWrite;
    logic     branch;
  } ctrl_t;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    ctrl.immKind = IMM_SIGN;
    unique case (opcode)
      OP_REG: begin
        ctrl.destRd = 1'b1;
        ctrl.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUBU: ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_XOR:  ctrl.aluOp = ALU_XOR;
          FN_NOR:  ctrl.aluOp = ALU_NOR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm = 1'b1;
      end
      OP_ANDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm = 1'b1;
        ctrl.immKind = IMM_ZERO;
        ctrl.aluOp = ALU_AND;
      end
      OP_ORI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm = 1'b1;
        ctrl.immKind = IMM_ZERO;
        ctrl.aluOp = ALU_OR;
      end
      OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm = 1'b1;
        ctrl.immKind = IMM_UPPER;
        ctrl.aluOp = ALU_PASS;
      end
      OP_LW: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm = 1'b1;
        ctrl.memToReg = 1'b1;
      end
      OP_SW: begin
        ctrl.useImm = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREG      = 32,
  parameter int MEM_WORDS = 256,
  localparam int MA    = $clog2(MEM_WORDS),
  localparam int RA    = $clog2(NREG),
  localparam int IMM_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic            loadToData,
  input  logic [MA-1:0]   loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  ctrl_t           ctrl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  input  logic [RA-1:0]   dbgRegAddr,
  output logic [XLEN-1:0] dbgPc,
  output logic [XLEN-1:0] dbgRegData
);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [XLEN-1:0] regFile [NREG];

  logic [XLEN-1:0] instr;
  logic [RA-1:0]   rsIdx, rtIdx, rdIdx, wrIdx;
  logic [4:0]      shamt;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0] rsVal, rtVal, immExt, opB, aluRes, wbVal;
  logic [XLEN-1:0] pcPlus4, pcNext, branchOff;
  logic [MA-1:0]   dIdx;
  logic            takeBranch;
  logic            unusedBits;

  // Fetch and field split
  assign instr  = imem[pc[MA+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm    = instr[IMM_W-1:0];

  // Immediate extension per class
  always_comb begin
    unique case (ctrl.immKind)
      IMM_ZERO:  immExt = {{(XLEN-IMM_W){1'b0}}, imm};
      IMM_UPPER: immExt = {imm, {(XLEN-IMM_W){1'b0}}};
      default:   immExt = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endcase
  end

  assign rsVal = regFile[rsIdx];
  assign rtVal = regFile[rtIdx];
  assign opB   = ctrl.useImm ? immExt : rtVal;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB:  aluRes = rsVal - opB;
      ALU_AND:  aluRes = rsVal & opB;
      ALU_OR:   aluRes = rsVal | opB;
      ALU_XOR:  aluRes = rsVal ^ opB;
      ALU_NOR:  aluRes = ~(rsVal | opB);
      ALU_SLT:  aluRes = {{(XLEN-1){1'b0}}, $signed(rsVal) < $signed(opB)};
      ALU_PASS: aluRes = opB;
      default:  aluRes = rsVal + opB;
    endcase
  end

  // Memory access and write-back selection
  assign dIdx  = aluRes[MA+1:2];
  assign wbVal = ctrl.memToReg ? dmem[dIdx] : aluRes;
  assign wrIdx = ctrl.destRd ? rdIdx : rtIdx;

  // Next program counter
  assign pcPlus4    = pc + XLEN'(4);
  assign branchOff  = {immExt[XLEN-3:0], 2'b00};
  assign takeBranch = ctrl.branch && (rsVal == rtVal);
  assign pcNext     = takeBranch ? pcPlus4 + branchOff : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (ctrl.regWrite && (wrIdx != '0)) begin
      regFile[wrIdx] <= wbVal;
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)       dmem[loadAddr] <= loadData;
    else if (!rst && ctrl.memWrite) dmem[dIdx] <= rtVal;
  end

  assign dbgPc      = pc;
  assign dbgRegData = regFile[dbgRegAddr];
  assign unusedBits = ^{shamt, pc[XLEN-1:MA+2], pc[1:0], aluRes[XLEN-1:MA+2], aluRes[1:0]};

  // Assertions
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == '0));
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    !ctrl.branch |=> (pc == $past(pc) + XLEN'(4)));
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst) regFile[0] == '0);
  a_r8_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite);
  a_r9_branch_no_wb: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> !(ctrl.regWrite || ctrl.memWrite));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREG      = 32,
  parameter int MEM_WORDS = 256,
  localparam int MA = $clog2(MEM_WORDS),
  localparam int RA = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic            loadToData,
  input  logic [MA-1:0]   loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  logic [RA-1:0]   dbgRegAddr,
  output logic [XLEN-1:0] dbgPc,
  output logic [XLEN-1:0] dbgRegData
);

  ctrl_t      ctrl;
  logic [5:0] opcode;
  logic [5:0] funct;

  cpu_control i_control (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  cpu_datapath #(
    .XLEN      (XLEN),
    .NREG      (NREG),
    .MEM_WORDS (MEM_WORDS)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .funct      (funct),
    .dbgRegAddr (dbgRegAddr),
    .dbgPc      (dbgPc),
    .dbgRegData (dbgRegData)
  );

endmodule

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegAddr = '0;
  logic [31:0] dbgPc;
  logic [31:0] dbgRegData;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [64];
  int          progLen;

  always #2.5 clk = ~clk;

  cpu_core i_cpu_core (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegAddr (dbgRegAddr),
    .dbgPc      (dbgPc),
    .dbgRegData (dbgRegData)
  );

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[progLen] = w;
    progLen++;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input int r, output logic [31:0] v);
    dbgRegAddr = 5'(r);
    #0.5;
    v = dbgRegData;
  endtask

  task automatic checkReg(input string req, input int r, input logic [31:0] exp);
    logic [31:0] v;
    readReg(r, v);
    check(req, $sformatf("r%0d", r), v, exp);
  endtask

  task automatic loadWord(input logic toData, input int addr, input logic [31:0] w);
    loadEn = 1'b1;
    loadToData = toData;
    loadAddr = 8'(addr);
    loadData = w;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runVector(input logic [31:0] a, input logic [31:0] b, input logic [15:0] k);
    logic [31:0] pre;
    logic [31:0] ks, kz;
    pre = a ^ 32'h5A5A_0F0F;
    ks  = {{16{k[15]}}, k};
    kz  = {16'h0000, k};
    progLen = 0;
    emit(encI(6'h0F, 0, 1, a[31:16]));   // 0 lui r1
    emit(encI(6'h0D, 1, 1, a[15:0]));    // 1 ori r1
    emit(encI(6'h0F, 0, 2, b[31:16]));   // 2 lui r2
    emit(encI(6'h0D, 2, 2, b[15:0]));    // 3 ori r2
    emit(encR(1, 2, 3, 6'h20));          // 4 add
    emit(encR(1, 2, 4, 6'h23));          // 5 subu
    emit(encR(1, 2, 5, 6'h24));          // 6 and
    emit(encR(1, 2, 6, 6'h25));          // 7 or
    emit(encR(1, 2, 7, 6'h26));          // 8 xor
    emit(encR(1, 2, 8, 6'h27));          // 9 nor
    emit(encR(1, 2, 9, 6'h2A));          // 10 slt
    emit(encI(6'h08, 1, 10, k));         // 11 addi
    emit(encI(6'h0C, 1, 11, k));         // 12 andi
    emit(encI(6'h0D, 0, 12, k));         // 13 ori from r0
    emit(encI(6'h0F, 0, 13, k));         // 14 lui
    emit(encI(6'h08, 0, 15, 16'd100));   // 15 r15 = 100
    emit(encI(6'h2B, 15, 3, 16'hFFFC));  // 16 sw r3, -4(r15)
    emit(encI(6'h23, 15, 14, 16'hFFFC)); // 17 lw r14, -4(r15)
    emit(encI(6'h08, 0, 0, 16'd5));      // 18 write to r0
    emit(encR(0, 0, 16, 6'h20));         // 19 r16 = r0 + r0
    emit(encI(6'h04, 1, 2, 16'd1));      // 20 beq r1,r2 skip 21
    emit(encI(6'h08, 0, 17, 16'd1));     // 21
    emit(encI(6'h08, 0, 18, 16'd2));     // 22
    emit(encI(6'h08, 0, 19, 16'd3));     // 23 loop count
    emit(encI(6'h08, 19, 19, 16'hFFFF)); // 24 decrement
    emit(encI(6'h04, 19, 0, 16'd1));     // 25 exit to 27
    emit(encI(6'h04, 0, 0, 16'hFFFD));   // 26 back to 24
    emit(encI(6'h3F, 0, 20, 16'h1234));  // 27 unknown opcode
    emit(encR(1, 2, 20, 6'h07));         // 28 unknown funct
    emit(encI(6'h23, 0, 21, 16'd200));   // 29 lw from preloaded word 50
    emit(encI(6'h04, 0, 0, 16'hFFFF));   // 30 halt

    rst = 1'b1;
    for (int i = 0; i < progLen; i++) loadWord(1'b0, i, prog[i]);
    loadWord(1'b1, 50, pre);
    // R1: reset clears pc and previously written registers
    check("R1", "pc in reset", dbgPc, 32'h0);
    checkReg("R1", 5, 32'h0);
    checkReg("R1", 3, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "pc after first step", dbgPc, 32'd4);
    repeat (80) @(negedge clk);

    checkReg("R3", 3, a + b);
    checkReg("R3", 4, a - b);
    checkReg("R3", 5, a & b);
    checkReg("R3", 6, a | b);
    checkReg("R3", 7, a ^ b);
    checkReg("R3", 8, ~(a | b));
    checkReg("R4", 9, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
    checkReg("R5", 10, a + ks);
    checkReg("R6", 11, a & kz);
    checkReg("R6", 12, kz);
    checkReg("R7", 13, {k, 16'h0000});
    checkReg("R8", 14, a + b);
    checkReg("R8", 21, pre);
    checkReg("R10", 0, 32'h0);
    checkReg("R10", 16, 32'h0);
    checkReg("R9", 17, (a == b) ? 32'd0 : 32'd1);
    checkReg("R9", 18, 32'd2);
    checkReg("R9", 19, 32'd0);
    checkReg("R11", 20, 32'h0);
    check("R9", "halt pc", dbgPc, 32'd120);
    @(negedge clk);
    check("R9", "halt pc held", dbgPc, 32'd120);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    runVector(32'h0000_0000, 32'h0000_0000, 16'h8001);
    runVector(32'h0000_0001, 32'h0000_0002, 16'h7FFF);
    runVector(32'hFFFF_FFFF, 32'h0000_0001, 16'hFFFF);
    runVector(32'h8000_0000, 32'h7FFF_FFFF, 16'h0000);
    runVector(32'h1234_5678, 32'h1234_5678, 16'h1234);
    runVector(32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h8000);
    runVector(32'hDEAD_BEEF, 32'h0BAD_F00D, 16'hA5C3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule